// File: doc/BRIEF.md
# UART Receiver with Line Status

This block turns an asynchronous serial line into a stream of characters and keeps line status for them. The line input is synchronised, then sampled once per pulse of a 16x oversampling tick. A falling edge starts a frame. The level is confirmed at the centre of the start bit. Each data bit, and the optional parity bit, is then sampled at its own centre. Finished characters go into a sixteen-entry receive queue. Each entry also records whether that character arrived with bad parity.

The host consumes characters with a one-cycle data read strobe, which removes the oldest entry. A separate one-cycle status read strobe clears the two sticky error flags.

The error flags work as follows:
- Overrun is raised when a character completes while the queue is full. That character is thrown away and the queued ones are kept.
- The parity flag follows the oldest queued character. It rises when a character recorded with bad parity becomes the oldest entry.

Top module: `uart_rx_status`

## Requirements
- R1: `dataReady` is 1 exactly while the receive queue holds at least one unread character, and 0 when the queue is empty.
- R2: A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit and a stop bit. Each bit lasts 16 ticks. The data length is chosen by `cfgDataBits`: 00 means 5 bits, 01 means 6, 10 means 7 and 11 means 8. Unused upper bits of `rxData` read as 0.
- R3: After a falling edge the line is sampled again 8 ticks later. If it reads high, the edge is treated as a glitch: the receiver returns to idle and nothing is stored.
- R4: When `cfgParityEn` is 1, a parity bit follows the data bits. `cfgParitySel` selects the rule: 00 means odd (data plus parity hold an odd number of ones), 01 means even, 10 means the bit must be 1, and 11 means it must be 0. A mismatch marks the stored entry as a parity error.
- R5: `parityErr` is set in the cycle in which an entry marked with a parity error becomes the head of the queue. This happens either when it is written into an empty queue or when the entry ahead of it is read.
- R6: When a character completes while 16 entries are queued, `overrunErr` is set in that same cycle. The new character is dropped and the queued entries are left unchanged.
- R7: A `statusRd` pulse clears `overrunErr` and `parityErr` at the next edge. If a new event for a flag occurs in the same cycle, that flag stays set.
- R8: A `dataRd` pulse removes the head entry. When the queue is empty, `dataRd` has no effect.
- R9: After reset, `dataReady`, `overrunErr` and `parityErr` are all 0.
- R10: Characters leave the queue in the order they arrived, and up to 16 can be held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxIn | input | 1 | Serial line, idle high |
| cfgDataBits | input | 2 | Character length code (5 to 8 bits) |
| cfgParityEn | input | 1 | Expect and check a parity bit |
| cfgParitySel | input | 2 | Parity rule: odd, even, forced 1, forced 0 |
| statusRd | input | 1 | Status read strobe, clears the error flags |
| dataRd | input | 1 | Data read strobe, removes the head entry |
| rxData | output | 8 | Character at the head of the queue |
| dataReady | output | 1 | Queue is not empty |
| overrunErr | output | 1 | Sticky overrun flag |
| parityErr | output | 1 | Sticky parity flag tied to the head entry |

## Verification
The bench fills the queue to exactly sixteen entries and then sends two more characters. A design that overwrote the tail, or shifted the queue, would return the wrong sixteen characters when drained.

It holds the status read strobe high while an overrun occurs. A design in which the clear beats the new event would never show the flag.

It queues a clean character ahead of a corrupted one. A design that raised the parity flag on arrival rather than when the entry reaches the head would report it one read too early.

It also sends:
- a short low glitch, which must not produce a character;
- a read strobe on an empty queue, which must not move the pointers;
- frames of every length and every parity rule.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // strobes from the bit-timing control to the datapath
  typedef struct packed {
    logic shiftBit;   // data bit centre: shift bitVal in
    logic capParity;  // parity bit centre: capture bitVal
    logic pushChar;   // stop bit centre: character complete
    logic bitVal;     // synchronised line level
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  output rxStrobe_t  strb
);

  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam logic [CW-1:0] HALF_M1 = CW'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(TICKS_PER_BIT - 1);

  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [2:0]    bitIdx;
  logic          rxMeta, rxSync;
  logic          midBit;
  logic [2:0]    lastIdx;

  assign midBit  = (tickCnt == FULL_M1);
  assign lastIdx = {1'b1, cfgDataBits};

  always_comb begin
    strb = '0;
    strb.bitVal = rxSync;
    if (tick && midBit) begin
      strb.shiftBit  = (state == ST_DATA);
      strb.capParity = (state == ST_PARITY);
      strb.pushChar  = (state == ST_STOP);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rxSync) begin
              state   <= ST_START;
              tickCnt <= '0;
            end
          end
          ST_START: begin
            if (tickCnt == HALF_M1) begin
              if (rxSync) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_DATA;
                tickCnt <= '0;
                bitIdx  <= '0;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (midBit) begin
              tickCnt <= '0;
              if (bitIdx == lastIdx) state <= cfgParityEn ? ST_PARITY : ST_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_PARITY: begin
            if (midBit) begin
              tickCnt <= '0;
              state   <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (midBit) state <= ST_IDLE;
            else        tickCnt <= tickCnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_PARITY_ONLY_IF_EN: assert property (@(posedge clk) disable iff (!rstN)
    strb.capParity |-> cfgParityEn); // R4

  AST_NO_DATA_AFTER_GLITCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !strb.shiftBit); // R3

endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic [1:0]        cfgParitySel,
  input  logic              statusRd,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              overrunErr,
  output logic              parityErr
);

  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int EW   = DATA_W + 1;

  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [DATA_W-1:0] charData;
  logic [2:0]        shAmt;
  logic              expPar;
  logic              entryErr;

  logic [EW-1:0]     mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [CNTW-1:0]   count;
  logic              full, empty, doPush, doPop, headSet, overEvt;

  // character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.shiftBit)  shiftReg <= {strb.bitVal, shiftReg[DATA_W-1:1]};
      if (strb.capParity) parBit   <= strb.bitVal;
    end
  end

  assign shAmt    = 3'd3 - {1'b0, cfgDataBits};
  assign charData = shiftReg >> shAmt;

  always_comb begin
    case (cfgParitySel)
      2'b00:   expPar = ~(^charData);
      2'b01:   expPar = ^charData;
      2'b10:   expPar = 1'b1;
      default: expPar = 1'b0;
    endcase
  end

  assign entryErr = cfgParityEn && (parBit != expPar);

  // receive queue
  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = strb.pushChar && !full;
  assign doPop   = dataRd && !empty;
  assign overEvt = strb.pushChar && full;

  assign headSet = (doPush && (empty || (doPop && count == CNTW'(1))) && entryErr)
                || (doPop && count > CNTW'(1) && mem[rdPtr + PW'(1)][DATA_W]);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {entryErr, charData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (overEvt)       overrunErr <= 1'b1;
      else if (statusRd) overrunErr <= 1'b0;
      if (headSet)       parityErr  <= 1'b1;
      else if (statusRd) parityErr  <= 1'b0;
    end
  end

  assign rxData    = mem[rdPtr][DATA_W-1:0];
  assign dataReady = !empty;

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushChar && full) |=> overrunErr); // R6

  AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushChar && full && !dataRd) |=> (full && $stable(wrPtr))); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(strb.pushChar && full)) |=> !overrunErr); // R7

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && empty && !strb.pushChar) |=> !dataReady); // R8

  AST_READY_ROSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(strb.pushChar)); // R1

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FIFO_DEPTH    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        rxIn,
  input  logic [1:0]  cfgDataBits,
  input  logic        cfgParityEn,
  input  logic [1:0]  cfgParitySel,
  input  logic        statusRd,
  input  logic        dataRd,
  output logic [7:0]  rxData,
  output logic        dataReady,
  output logic        overrunErr,
  output logic        parityErr
);

  rxStrobe_t strb;

  uart_rx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick16),
    .rxIn        (rxIn),
    .cfgDataBits (cfgDataBits),
    .cfgParityEn (cfgParityEn),
    .strb        (strb)
  );

  uart_rx_dpath #(.DEPTH(FIFO_DEPTH)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgDataBits  (cfgDataBits),
    .cfgParityEn  (cfgParityEn),
    .cfgParitySel (cfgParitySel),
    .statusRd     (statusRd),
    .dataRd       (dataRd),
    .rxData       (rxData),
    .dataReady    (dataReady),
    .overrunErr   (overrunErr),
    .parityErr    (parityErr)
  );

endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16 = 1'b0;
  logic       rxIn;
  logic [1:0] cfgDataBits;
  logic       cfgParityEn;
  logic [1:0] cfgParitySel;
  logic       statusRd, dataRd;
  logic [7:0] rxData;
  logic       dataReady, overrunErr, parityErr;

  logic monRd = 1'b0, monStat = 1'b0, manRd = 1'b0, manStat = 1'b0;
  logic autoDrain = 1'b0;
  logic txBusy = 1'b0;
  int   nChecks = 0, nFails = 0;
  bit   finished = 1'b0;
  logic [8:0] expQ [$];

  assign dataRd   = monRd | manRd;
  assign statusRd = monStat | manStat;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_status dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxIn(rxIn),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn), .cfgParitySel(cfgParitySel),
    .statusRd(statusRd), .dataRd(dataRd), .rxData(rxData),
    .dataReady(dataReady), .overrunErr(overrunErr), .parityErr(parityErr)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick16 = (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic setCfg(input logic [1:0] db, input logic pe, input logic [1:0] ps);
    cfgDataBits = db; cfgParityEn = pe; cfgParitySel = ps;
  endtask

  // driver: frames one character, pushes the expected entry into the scoreboard
  task automatic sendChar(input logic [7:0] d, input bit corrupt, input bit expPush);
    int nb = 5 + int'(cfgDataBits);
    logic [7:0] m = d & 8'((1 << nb) - 1);
    logic p;
    case (cfgParitySel)
      2'b00:   p = ~(^m);
      2'b01:   p = ^m;
      2'b10:   p = 1'b1;
      default: p = 1'b0;
    endcase
    if (corrupt) p = ~p;
    if (expPush) expQ.push_back({corrupt && cfgParityEn, m});
    txBusy = 1'b1;
    rxIn = 1'b0; repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxIn = m[i]; repeat (BIT_CLKS) @(negedge clk);
    end
    if (cfgParityEn) begin
      rxIn = p; repeat (BIT_CLKS) @(negedge clk);
    end
    rxIn = 1'b1; repeat (BIT_CLKS + BIT_CLKS / 2) @(negedge clk);
    txBusy = 1'b0;
  endtask

  // manual read of the head entry against the scoreboard
  task automatic readHead(input string tag);
    logic [8:0] e;
    if (expQ.size() == 0) begin
      chk(1'b0, tag, 0, 1);
      return;
    end
    e = expQ.pop_front();
    chk(rxData == e[7:0], tag, rxData, e[7:0]);
    manRd = 1'b1; @(negedge clk); manRd = 1'b0;
  endtask

  // monitor: drains the queue while autoDrain is set
  initial begin
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (autoDrain && dataReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R1 unexpected character", rxData, 0);
        end else begin
          e = expQ.pop_front();
          chk(rxData == e[7:0], "R2/R10 character value", rxData, e[7:0]);
          chk(parityErr == e[8], "R4/R5 parity flag of head", parityErr, e[8]);
        end
        monRd = 1'b1; monStat = 1'b1;
        @(negedge clk);
        monRd = 1'b0; monStat = 1'b0;
        chk(parityErr == 1'b0, "R7 status read clears parity", parityErr, 0);
        chk(dataReady == 1'b0, "R1 ready drops when empty", dataReady, 0);
      end
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    int hits;
    rstN = 1'b0; rxIn = 1'b1;
    setCfg(2'b11, 1'b0, 2'b00);
    repeat (5) @(negedge clk);
    chk(dataReady == 0,  "R9 reset dataReady", dataReady, 0);
    chk(overrunErr == 0, "R9 reset overrunErr", overrunErr, 0);
    chk(parityErr == 0,  "R9 reset parityErr", parityErr, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // R2, R10: eight-bit frames, no parity, drained by the monitor
    autoDrain = 1'b1;
    sendChar(8'h55, 0, 1); sendChar(8'hA3, 0, 1);
    sendChar(8'h00, 0, 1); sendChar(8'hFF, 0, 1);

    // R2, R4: other lengths and each parity rule, good parity
    setCfg(2'b00, 1'b1, 2'b00); sendChar(8'hFB, 0, 1); sendChar(8'h16, 0, 1);
    setCfg(2'b10, 1'b1, 2'b01); sendChar(8'h6D, 0, 1);
    setCfg(2'b01, 1'b1, 2'b10); sendChar(8'h2A, 0, 1);
    setCfg(2'b11, 1'b1, 2'b11); sendChar(8'hC3, 0, 1);

    // R4, R5: corrupted parity under each rule
    setCfg(2'b11, 1'b1, 2'b00); sendChar(8'h4E, 1, 1);
    setCfg(2'b11, 1'b1, 2'b01); sendChar(8'h4E, 1, 1);
    setCfg(2'b10, 1'b1, 2'b10); sendChar(8'h11, 1, 1);
    setCfg(2'b00, 1'b1, 2'b11); sendChar(8'h09, 1, 1);
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R1 every frame delivered", expQ.size(), 0);

    // R3: short glitch, then a real frame
    setCfg(2'b11, 1'b0, 2'b00);
    rxIn = 1'b0; repeat (3 * TICK_DIV) @(negedge clk);
    rxIn = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
    chk(dataReady == 0, "R3 glitch stores nothing", dataReady, 0);
    sendChar(8'h3C, 0, 1);
    repeat (10) @(negedge clk);
    autoDrain = 1'b0;

    // R8: read strobe on an empty queue has no effect
    manRd = 1'b1; @(negedge clk); manRd = 1'b0;
    chk(dataReady == 0, "R8 empty read keeps queue empty", dataReady, 0);
    sendChar(8'h81, 0, 1);
    chk(dataReady == 1, "R1 ready with one entry", dataReady, 1);
    readHead("R8 empty read left pointers intact");
    chk(dataReady == 0, "R8 pop empties queue", dataReady, 0);

    // R5: parity flag follows the head entry
    setCfg(2'b11, 1'b1, 2'b01);
    sendChar(8'h12, 0, 1); sendChar(8'h34, 1, 1);
    chk(parityErr == 0, "R5 clean head, flag low", parityErr, 0);
    readHead("R10 first of pair");
    chk(parityErr == 1, "R5 flag rises when bad entry becomes head", parityErr, 1);
    manStat = 1'b1; @(negedge clk); manStat = 1'b0;
    chk(parityErr == 0, "R7 status read clears parity", parityErr, 0);
    readHead("R10 second of pair");

    // R6, R10: fill sixteen, overflow, set-wins on clear
    setCfg(2'b11, 1'b0, 2'b00);
    for (int i = 0; i < 16; i++) sendChar(8'(i * 7 + 3), 0, 1);
    chk(overrunErr == 0, "R6 no overrun at exactly 16", overrunErr, 0);
    sendChar(8'hEE, 0, 0);
    chk(overrunErr == 1, "R6 overrun on 17th character", overrunErr, 1);
    manStat = 1'b1; @(negedge clk);
    chk(overrunErr == 0, "R7 status read clears overrun", overrunErr, 0);
    hits = 0;
    fork
      sendChar(8'hDD, 0, 0);
      begin
        @(negedge clk);
        while (txBusy) begin
          if (overrunErr) hits++;
          @(negedge clk);
        end
      end
    join
    manStat = 1'b0;
    chk(hits == 1, "R7 new overrun wins over same-cycle clear", hits, 1);
    for (int i = 0; i < 16; i++) readHead("R6 queue unchanged by overrun");
    chk(dataReady == 0, "R1 ready low after drain", dataReady, 0);

    repeat (10) @(negedge clk);
    finish();
  end

endmodule